// File: doc/BRIEF.md
# Interrupt State Bank

This block keeps the bookkeeping state of an interrupt controller: one enable bit, one pending bit and one active bit for every interrupt ID, up to `NUM_IRQ` IDs (128 by default). Software reaches the state through a 32-bit memory-mapped port. Each of the three state kinds has a write-one-to-set word and a write-one-to-clear word, and both words read back the same current state. A global forwarding switch and a read-only geometry word sit in the first page of the map.

Peripheral request lines mark interrupts pending. A CPU-side interface then moves them through their life cycle. An acknowledge strobe turns a pending interrupt into an active one, and an end-of-interrupt strobe retires it. IDs 0 to 15 are software-generated: their request lines are not wired, and their enables are permanently on. IDs 16 to 31 are per-processor peripheral interrupts, and IDs from 32 upward are shared peripheral interrupts.

A combinational output reports whether any interrupt is ready to forward, and which one. Priorities, targets and trigger configuration belong to other blocks.

Top module: `irq_state_bank`

## Requirements
- R1: After reset, forwarding is off, every pending and active bit is 0, enables for IDs 16 and up are 0, enables for IDs 0 to 15 are 1, and `fwd_valid` is 0.
- R2: Bit 0 of the word at 0x000 is the forwarding switch. It can be read and written, and the other bits of that word read 0. While the switch is 0, `fwd_valid` is 0.
- R3: The word at 0x004 is read-only. Bits [4:0] hold NUM_IRQ/32 − 1, bits [7:5] hold NUM_CPU − 1, and the other bits are 0. With the defaults it reads 0x00000003, and writes to it change nothing.
- R4: Enable word w is set through 0x100+4w and cleared through 0x180+4w, and bit b of the word belongs to ID 32w+b. A 1 in the written data sets or clears that bit, a 0 leaves it unchanged, and both addresses read the current enables. Enables of IDs 0 to 15 always read 1.
- R5: Pending state uses the pair 0x200+4w / 0x280+4w, and active state uses the pair 0x300+4w / 0x380+4w. Both follow the same set, clear and read rules as R4. When a bit is set and cleared in the same cycle, the clear wins.
- R6: A high `irq_lines[i]` for i ≥ 16 sets pending bit i in each cycle in which ID i is not active. This means a line still held high marks the ID pending again one cycle after its active bit clears. `irq_lines[15:0]` are ignored.
- R7: An acknowledge strobe clears the pending bit of `ack_id` and sets its active bit. Both changes are visible on the next cycle. This clear beats a line or software set of the same pending bit in that cycle.
- R8: An end-of-interrupt strobe clears the active bit of `eoi_id` on the next cycle. It beats an acknowledge or a software set of the same bit in that cycle.
- R9: `fwd_valid` is 1 exactly when the switch is on and some ID is enabled, pending and not active. In that case `fwd_id` is the lowest such ID. Both outputs follow the state without delay.
- R10: The following accesses read 0, and writes to them are ignored: any address with bits [1:0] not zero, state words with w ≥ NUM_IRQ/32 (for example 0x110), and every address outside the words above (for example 0x008, 0x010, 0x400).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_lines | input | 128 | Level request line per ID (bits 15:0 unused) |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_id | input | 7 | ID being acknowledged |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_id | input | 7 | ID being retired |
| fwd_valid | output | 1 | Some ID is ready to forward |
| fwd_id | output | 7 | Lowest ready ID |

## Verification
The bench targets the ordering rules. It sets and clears the same bit in one cycle, acknowledges an ID while software sets it pending, and retires an ID while software sets it active. A design with the wrong precedence would leave a stale pending or active bit that then blocks or repeats forwarding. It holds a level line high through acknowledge and end-of-interrupt. A design that ignores the active gate re-pends too early, and one that latches only edges never re-pends. It also probes the fixed software-generated enables, unimplemented and misaligned words, and the forwarding switch. Wrong decoding there shows up as phantom bits or lost enables. Against a behavioural model, it checks every cycle that the lowest ready ID is reported.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

   localparam int unsigned BANK_ADDR_W = 12;
   localparam int unsigned BANK_DATA_W = 32;
   localparam int unsigned SGI_COUNT   = 16;

   // page select taken from address bits [11:8]
   localparam logic [3:0] PAGE_GLOBAL = 4'h0;
   localparam logic [3:0] PAGE_ENABLE = 4'h1;
   localparam logic [3:0] PAGE_PEND   = 4'h2;
   localparam logic [3:0] PAGE_ACTIVE = 4'h3;

   // offsets within the global page
   localparam logic [7:0] OFS_SWITCH = 8'h00;
   localparam logic [7:0] OFS_GEOM   = 8'h04;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_SWITCH,
      SEL_GEOM,
      SEL_ENABLE,
      SEL_PEND,
      SEL_ACTIVE
   } sel_e;

   typedef struct packed {
      sel_e       sel;
      logic       clr;
      logic [4:0] word;
      logic       word_ok;
   } dec_t;

endpackage

// File: rtl/irq_addr_decode.sv
module irq_addr_decode
   import irq_bank_pkg::*;
#(
   parameter int unsigned NUM_WORDS = 4
) (
   input  logic [BANK_ADDR_W-1:0] addr,
   output dec_t                   dec
);

   logic aligned;
   logic is_state;

   assign aligned = (addr[1:0] == 2'b00);

   always_comb begin
      dec.sel  = SEL_NONE;
      dec.clr  = addr[7];
      dec.word = addr[6:2];
      if (aligned) begin
         case (addr[11:8])
            PAGE_GLOBAL: begin
               if (addr[7:0] == OFS_SWITCH)    dec.sel = SEL_SWITCH;
               else if (addr[7:0] == OFS_GEOM) dec.sel = SEL_GEOM;
            end
            PAGE_ENABLE: dec.sel = SEL_ENABLE;
            PAGE_PEND:   dec.sel = SEL_PEND;
            PAGE_ACTIVE: dec.sel = SEL_ACTIVE;
            default:     dec.sel = SEL_NONE;
         endcase
      end
   end

   assign is_state    = (dec.sel == SEL_ENABLE) || (dec.sel == SEL_PEND) ||
                        (dec.sel == SEL_ACTIVE);
   assign dec.word_ok = is_state && (int'(addr[6:2]) < int'(NUM_WORDS));

endmodule

// File: rtl/irq_state_word.sv
module irq_state_word
   import irq_bank_pkg::*;
#(
   parameter logic [BANK_DATA_W-1:0] FIXED_EN  = '0,
   parameter logic [BANK_DATA_W-1:0] LINE_MASK = '1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [BANK_DATA_W-1:0] en_set,
   input  logic [BANK_DATA_W-1:0] en_clr,
   input  logic [BANK_DATA_W-1:0] pend_set,
   input  logic [BANK_DATA_W-1:0] pend_clr,
   input  logic [BANK_DATA_W-1:0] act_set,
   input  logic [BANK_DATA_W-1:0] act_clr,
   input  logic [BANK_DATA_W-1:0] line,
   input  logic [BANK_DATA_W-1:0] ack_hit,
   input  logic [BANK_DATA_W-1:0] eoi_hit,
   output logic [BANK_DATA_W-1:0] en_q,
   output logic [BANK_DATA_W-1:0] pend_q,
   output logic [BANK_DATA_W-1:0] act_q
);

   logic [BANK_DATA_W-1:0] pend_up, pend_down, act_up, act_down;

   // a level line only re-arms pending once the ID is no longer active
   assign pend_up   = pend_set | (line & LINE_MASK & ~act_q);
   assign pend_down = pend_clr | ack_hit;
   assign act_up    = act_set | ack_hit;
   assign act_down  = act_clr | eoi_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= FIXED_EN;
         pend_q <= '0;
         act_q  <= '0;
      end else begin
         en_q   <= ((en_q | en_set) & ~en_clr) | FIXED_EN;
         pend_q <= (pend_q | pend_up) & ~pend_down;
         act_q  <= (act_q | act_up) & ~act_down;
      end
   end

endmodule

// File: rtl/irq_first_find.sv
module irq_first_find #(
   parameter int unsigned N   = 128,
   parameter int unsigned IDW = $clog2(N)
) (
   input  logic [N-1:0]   req,
   output logic           found,
   output logic [IDW-1:0] idx
);

   assign found = |req;

   // scan from the top so the lowest set bit is the last assignment
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IDW'(i);
      end
   end

endmodule

// File: rtl/irq_state_bank.sv
module irq_state_bank
   import irq_bank_pkg::*;
#(
   parameter int unsigned NUM_IRQ = 128,
   parameter int unsigned NUM_CPU = 1,
   localparam int unsigned ID_W      = $clog2(NUM_IRQ),
   localparam int unsigned NUM_WORDS = NUM_IRQ / BANK_DATA_W
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [BANK_ADDR_W-1:0] bus_addr,
   input  logic                   bus_wr,
   input  logic [BANK_DATA_W-1:0] bus_wdata,
   output logic [BANK_DATA_W-1:0] bus_rdata,
   input  logic [NUM_IRQ-1:0]     irq_lines,
   input  logic                   ack_valid,
   input  logic [ID_W-1:0]        ack_id,
   input  logic                   eoi_valid,
   input  logic [ID_W-1:0]        eoi_id,
   output logic                   fwd_valid,
   output logic [ID_W-1:0]        fwd_id
);

   if ((NUM_IRQ % BANK_DATA_W) != 0 || NUM_IRQ < BANK_DATA_W || NUM_IRQ > 1024) begin : g_bad_irq
      $error("NUM_IRQ must be a multiple of 32 between 32 and 1024");
   end
   if (NUM_CPU < 1 || NUM_CPU > 8) begin : g_bad_cpu
      $error("NUM_CPU must lie between 1 and 8");
   end

   localparam logic [BANK_DATA_W-1:0] GEOM_WORD =
      {24'h0, 3'(NUM_CPU - 1), 5'(NUM_WORDS - 1)};

   dec_t                 dec;
   logic                 ctrl_q;
   logic [NUM_IRQ-1:0]   en_vec, pend_vec, act_vec;
   logic [NUM_IRQ-1:0]   ack_vec, eoi_vec, ready_vec;
   logic [NUM_IRQ-1:0]   one_hot_base;

   irq_addr_decode #(.NUM_WORDS(NUM_WORDS)) u_dec (
      .addr (bus_addr),
      .dec  (dec)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             ctrl_q <= 1'b0;
      else if (bus_wr && dec.sel == SEL_SWITCH) ctrl_q <= bus_wdata[0];
   end

   assign one_hot_base = {{(NUM_IRQ-1){1'b0}}, 1'b1};
   assign ack_vec = ack_valid ? (one_hot_base << ack_id) : '0;
   assign eoi_vec = eoi_valid ? (one_hot_base << eoi_id) : '0;

   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      localparam logic [BANK_DATA_W-1:0] FIX_EN =
         (w == 0) ? BANK_DATA_W'((64'd1 << SGI_COUNT) - 1) : '0;
      localparam logic [BANK_DATA_W-1:0] LMASK = ~FIX_EN;

      logic                   hit;
      logic [BANK_DATA_W-1:0] set_d, clr_d;

      assign hit   = bus_wr && dec.word_ok && (dec.word == 5'(w));
      assign set_d = (hit && !dec.clr) ? bus_wdata : '0;
      assign clr_d = (hit &&  dec.clr) ? bus_wdata : '0;

      irq_state_word #(.FIXED_EN(FIX_EN), .LINE_MASK(LMASK)) u_word (
         .clk      (clk),
         .rst_n    (rst_n),
         .en_set   ((dec.sel == SEL_ENABLE) ? set_d : '0),
         .en_clr   ((dec.sel == SEL_ENABLE) ? clr_d : '0),
         .pend_set ((dec.sel == SEL_PEND)   ? set_d : '0),
         .pend_clr ((dec.sel == SEL_PEND)   ? clr_d : '0),
         .act_set  ((dec.sel == SEL_ACTIVE) ? set_d : '0),
         .act_clr  ((dec.sel == SEL_ACTIVE) ? clr_d : '0),
         .line     (irq_lines[w*BANK_DATA_W +: BANK_DATA_W]),
         .ack_hit  (ack_vec[w*BANK_DATA_W +: BANK_DATA_W]),
         .eoi_hit  (eoi_vec[w*BANK_DATA_W +: BANK_DATA_W]),
         .en_q     (en_vec[w*BANK_DATA_W +: BANK_DATA_W]),
         .pend_q   (pend_vec[w*BANK_DATA_W +: BANK_DATA_W]),
         .act_q    (act_vec[w*BANK_DATA_W +: BANK_DATA_W])
      );
   end

   always_comb begin
      bus_rdata = '0;
      case (dec.sel)
         SEL_SWITCH: bus_rdata = {{(BANK_DATA_W-1){1'b0}}, ctrl_q};
         SEL_GEOM:   bus_rdata = GEOM_WORD;
         SEL_ENABLE: if (dec.word_ok) bus_rdata = en_vec[int'(dec.word)*BANK_DATA_W +: BANK_DATA_W];
         SEL_PEND:   if (dec.word_ok) bus_rdata = pend_vec[int'(dec.word)*BANK_DATA_W +: BANK_DATA_W];
         SEL_ACTIVE: if (dec.word_ok) bus_rdata = act_vec[int'(dec.word)*BANK_DATA_W +: BANK_DATA_W];
         default:    bus_rdata = '0;
      endcase
   end

   assign ready_vec = ctrl_q ? (en_vec & pend_vec & ~act_vec) : '0;

   irq_first_find #(.N(NUM_IRQ), .IDW(ID_W)) u_find (
      .req   (ready_vec),
      .found (fwd_valid),
      .idx   (fwd_id)
   );

endmodule

// File: rtl/irq_state_bank_chk.sv
module irq_state_bank_chk #(
   parameter int unsigned NUM_IRQ = 128,
   localparam int unsigned ID_W = $clog2(NUM_IRQ)
) (
   input logic               clk,
   input logic               rst_n,
   input logic               bus_wr,
   input logic               ack_valid,
   input logic [ID_W-1:0]    ack_id,
   input logic               eoi_valid,
   input logic [ID_W-1:0]    eoi_id,
   input logic               fwd_valid,
   input logic [ID_W-1:0]    fwd_id,
   input logic               ctrl_q,
   input logic [NUM_IRQ-1:0] en_vec,
   input logic [NUM_IRQ-1:0] pend_vec,
   input logic [NUM_IRQ-1:0] act_vec
);

   logic [NUM_IRQ-1:0] below_mask;
   assign below_mask = ({{(NUM_IRQ-1){1'b0}}, 1'b1} << fwd_id) - 1'b1;

   p_switch_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_q |-> !fwd_valid);

   p_ack_moves_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_valid && !eoi_valid && !bus_wr) |=>
         (act_vec[$past(ack_id)] && !pend_vec[$past(ack_id)]));

   p_eoi_retires_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_valid && !ack_valid && !bus_wr) |=> !act_vec[$past(eoi_id)]);

   p_fwd_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_valid |-> (en_vec[fwd_id] && pend_vec[fwd_id] && !act_vec[fwd_id]));

   p_fwd_lowest_r9: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_valid |-> ((en_vec & pend_vec & ~act_vec & below_mask) == '0));

endmodule

bind irq_state_bank irq_state_bank_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .ack_valid (ack_valid),
   .ack_id    (ack_id),
   .eoi_valid (eoi_valid),
   .eoi_id    (eoi_id),
   .fwd_valid (fwd_valid),
   .fwd_id    (fwd_id),
   .ctrl_q    (ctrl_q),
   .en_vec    (en_vec),
   .pend_vec  (pend_vec),
   .act_vec   (act_vec)
);

// File: tb/irq_state_bank_tb.sv
`timescale 1ns/100ps
module irq_state_bank_tb_top;

   localparam int N = 128;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [11:0]  bus_addr = '0;
   logic         bus_wr = 1'b0;
   logic [31:0]  bus_wdata = '0;
   logic [31:0]  bus_rdata;
   logic [N-1:0] irq_lines = '0;
   logic         ack_valid = 1'b0;
   logic [6:0]   ack_id = '0;
   logic         eoi_valid = 1'b0;
   logic [6:0]   eoi_id = '0;
   logic         fwd_valid;
   logic [6:0]   fwd_id;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   bit live = 0;

   always #2 clk = ~clk;

   irq_state_bank dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_lines(irq_lines),
      .ack_valid(ack_valid), .ack_id(ack_id), .eoi_valid(eoi_valid),
      .eoi_id(eoi_id), .fwd_valid(fwd_valid), .fwd_id(fwd_id)
   );

   // behavioural reference of the state bits
   logic [N-1:0] m_en, m_pend, m_act;
   logic         m_ctrl;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_en = '0; m_en[15:0] = '1; m_pend = '0; m_act = '0; m_ctrl = 0;
      end else begin
         logic [N-1:0] es, ec, ps, pc, as_, ac, av, ev, msk;
         int page, w;
         es = '0; ec = '0; ps = '0; pc = '0; as_ = '0; ac = '0;
         page = int'(bus_addr[11:8]);
         w    = int'(bus_addr[6:2]);
         if (bus_wr && bus_addr[1:0] == 0) begin
            if (bus_addr == 12'h000) m_ctrl = bus_wdata[0];
            else if (page >= 1 && page <= 3 && w < N/32) begin
               msk = N'(bus_wdata) << (w*32);
               case ({page[1:0], bus_addr[7]})
                  3'b010: es = msk;  3'b011: ec = msk;
                  3'b100: ps = msk;  3'b101: pc = msk;
                  3'b110: as_ = msk; 3'b111: ac = msk;
                  default: ;
               endcase
            end
         end
         av = ack_valid ? (N'(1) << ack_id) : '0;
         ev = eoi_valid ? (N'(1) << eoi_id) : '0;
         m_pend = (m_pend | ps | (irq_lines & ~N'(16'hFFFF) & ~m_act)) & ~(pc | av);
         m_act  = (m_act | as_ | av) & ~(ac | ev);
         m_en   = (m_en | es) & ~ec;
         m_en[15:0] = '1;
      end
   end

   // R9: forwarding outputs compared with the model every cycle
   always @(negedge clk) begin
      if (live) begin
         bit ev_ok; int eid;
         ev_ok = 0; eid = 0;
         for (int i = N - 1; i >= 0; i--)
            if (m_ctrl && m_en[i] && m_pend[i] && !m_act[i]) begin ev_ok = 1; eid = i; end
         checks++;
         if (fwd_valid !== ev_ok || (ev_ok && fwd_id !== 7'(eid))) begin
            errors++;
            $display("FAIL R9 forward: got valid=%0b id=%0d, expected valid=%0b id=%0d",
                     fwd_valid, fwd_id, ev_ok, eid);
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got 0x%08h, expected 0x%08h", tag, got, exp);
      end
   endtask

   task automatic rd(input string tag, input logic [11:0] a, input logic [31:0] exp);
      bus_addr = a;
      #0.1;
      chk(tag, bus_rdata, exp);
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1;
      @(negedge clk);
      bus_wr = 0;
   endtask

   task automatic ack(input int id);
      @(negedge clk); ack_valid = 1; ack_id = 7'(id);
      @(negedge clk); ack_valid = 0;
   endtask

   task automatic eoi(input int id);
      @(negedge clk); eoi_valid = 1; eoi_id = 7'(id);
      @(negedge clk); eoi_valid = 0;
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got hung run, expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      rd("R1 switch", 12'h000, 32'h0);
      rd("R1 enable w0", 12'h100, 32'h0000FFFF);
      rd("R1 enable w1", 12'h104, 32'h0);
      rd("R1 pending w0", 12'h200, 32'h0);
      rd("R1 active w3", 12'h30C, 32'h0);
      chk("R1 fwd_valid", 32'(fwd_valid), 32'h0);
      rst_n = 1;
      tick();
      live = 1;

      // R3 geometry word
      rd("R3 geometry", 12'h004, 32'h3);
      wr(12'h004, 32'hFFFF_FFFF);
      rd("R3 geometry after write", 12'h004, 32'h3);

      // R4 enable pair
      wr(12'h104, 32'hA5);
      rd("R4 set view", 12'h104, 32'hA5);
      rd("R4 clear view", 12'h184, 32'hA5);
      wr(12'h184, 32'h05);
      rd("R4 after clear", 12'h104, 32'hA0);
      wr(12'h104, 32'h0);
      rd("R4 zero write", 12'h104, 32'hA0);
      wr(12'h180, 32'hFFFF_FFFF);
      rd("R4 fixed SGI enables", 12'h100, 32'h0000FFFF);
      wr(12'h184, 32'hFFFF_FFFF);
      rd("R4 cleared word", 12'h104, 32'h0);

      // R5 pending and active pairs
      wr(12'h208, 32'h8);
      rd("R5 pend set", 12'h208, 32'h8);
      rd("R5 pend clear view", 12'h288, 32'h8);
      wr(12'h288, 32'h8);
      rd("R5 pend clear", 12'h208, 32'h0);
      wr(12'h30C, 32'h1);
      rd("R5 active set", 12'h38C, 32'h1);
      wr(12'h38C, 32'h1);
      rd("R5 active clear", 12'h30C, 32'h0);

      // R2 forwarding switch
      wr(12'h108, 32'h8);
      wr(12'h208, 32'h8);
      chk("R2 switch off blocks", 32'(fwd_valid), 32'h0);
      wr(12'h000, 32'hFFFF_FFFF);
      rd("R2 switch readback", 12'h000, 32'h1);
      chk("R2 switch on forwards", {31'h0, fwd_valid}, 32'h1);
      chk("R9 id 67", 32'(fwd_id), 32'd67);

      // R9 lowest wins
      wr(12'h104, 32'h100);
      wr(12'h204, 32'h100);
      chk("R9 id 40", 32'(fwd_id), 32'd40);
      wr(12'h200, 32'h20);
      chk("R9 SGI 5", 32'(fwd_id), 32'd5);

      // R7 / R8 life cycle
      ack(5);
      rd("R7 pend cleared", 12'h200, 32'h0);
      rd("R7 active set", 12'h300, 32'h20);
      chk("R7 next candidate", 32'(fwd_id), 32'd40);
      eoi(5);
      rd("R8 active cleared", 12'h300, 32'h0);
      ack(40); eoi(40);
      chk("R9 after 40 retired", 32'(fwd_id), 32'd67);
      ack(67); eoi(67);
      chk("R9 nothing ready", 32'(fwd_valid), 32'h0);

      // R6 level lines
      irq_lines[3] = 1; tick(); tick();
      rd("R6 SGI line ignored", 12'h200, 32'h0);
      irq_lines[3] = 0;
      wr(12'h108, 32'h40);
      irq_lines[70] = 1; tick();
      rd("R6 line pends", 12'h208, 32'h40);
      chk("R6 forward 70", 32'(fwd_id), 32'd70);
      ack(70);
      rd("R6 no repend while active", 12'h208, 32'h0);
      rd("R7 active 70", 12'h308, 32'h40);
      tick(); tick();
      rd("R6 still not pending", 12'h208, 32'h0);
      eoi(70);
      rd("R8 active 70 cleared", 12'h308, 32'h0);
      rd("R6 one cycle gap", 12'h208, 32'h0);
      tick();
      rd("R6 repend after eoi", 12'h208, 32'h40);
      irq_lines[70] = 0;
      wr(12'h288, 32'h40);
      rd("R6 cleared", 12'h208, 32'h0);

      // R7 / R8 conflicts
      wr(12'h204, 32'h40000);
      @(negedge clk);
      ack_valid = 1; ack_id = 7'd50;
      bus_addr = 12'h204; bus_wdata = 32'h40000; bus_wr = 1;
      @(negedge clk);
      ack_valid = 0; bus_wr = 0;
      rd("R7 ack beats pend set", 12'h204, 32'h0);
      rd("R7 ack activates", 12'h304, 32'h40000);
      @(negedge clk);
      eoi_valid = 1; eoi_id = 7'd50;
      bus_addr = 12'h304; bus_wdata = 32'h40000; bus_wr = 1;
      @(negedge clk);
      eoi_valid = 0; bus_wr = 0;
      rd("R8 eoi beats active set", 12'h304, 32'h0);

      // R10 unimplemented space
      wr(12'h110, 32'hFFFF_FFFF);
      rd("R10 word beyond range", 12'h110, 32'h0);
      rd("R10 clear view beyond range", 12'h190, 32'h0);
      rd("R10 hole", 12'h010, 32'h0);
      rd("R10 page 4", 12'h400, 32'h0);
      wr(12'h008, 32'h1);
      rd("R10 ignored write", 12'h008, 32'h0);
      wr(12'h101, 32'hFFFF_FFFF);
      rd("R10 misaligned read", 12'h101, 32'h0);
      rd("R10 misaligned write ignored", 12'h100, 32'h0000FFFF);
      rd("R2 switch kept", 12'h000, 32'h1);

      tick(); tick();
      done = 1;
      live = 0;
      summary();
      $finish;
   end

endmodule